// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Engine

The block watches the demodulated output of an infrared receiver, an active-low signal that sits high when no light arrives. The input passes through a two-flop synchronizer. A de-glitch filter then accepts a level change only after the new level has held for a programmed number of sample ticks. A prescaler derives the sample tick from the system clock. The block measures each accepted pulse (low) and each space (high) as a count of ticks and keeps every measurement as one byte in a 68-entry capture store. Software reads that store as seventeen 32-bit words.

A message ends in one of two ways. The first is a space that runs past the programmed completion count, which is scaled by 256 ticks. That space is written as zero, and so is every entry after it. The second is the store filling up. In both cases a pending flag is set and, if enabled, drives a level interrupt. Software reads the words, writes the restart bit to clear the store and re-arm the engine, then acknowledges the pending flag. The register port is plain: a write takes effect on the clock edge, and read data is a combinational function of the address. Nothing in it stalls, so there is no back-pressure to manage.

Registers, by word address: 0 configuration, 1 filter, 2 sample period, 3 restart, 4 interrupt enable, 5 interrupt status and acknowledge, 16 to 32 capture words 0 to 16.

Top module: `ircap_top`

## Requirements
- R1: Entries alternate strictly between pulse and space, starting with a pulse. Each entry holds the number of sample ticks between two accepted edges.
- R2: A width above 255 ticks is stored as 0xFF and never wraps.
- R3: A space of at least completion-count × 256 ticks is stored as 0x00, and all later entries stay 0x00. The message then ends and the pending flag is set. A completion count of 0 disables this timeout.
- R4: When entry 68 has been written, the message ends and the pending flag is set. Later edges are discarded and no stored word changes.
- R5: Capture word k sits at address 16+k and holds entries 4k to 4k+3, with the earliest entry in bits 7:0.
- R6: Writing 1 to bit 0 of address 3 zeroes every capture word and returns the engine to idle. The next falling edge then starts a new message at entry 0.
- R7: Address 4 bit 0 is the interrupt enable. irq_o is high only when both the enable and the pending flag are set. Reading address 5 bit 0 returns the pending flag, and writing 1 to address 5 bit 0 clears it.
- R8: Address 0 holds the block enable in bit 0, the measurement enable in bit 13, and the completion count in bits 22:16. Unless both enables are 1, nothing is captured.
- R9: Address 1 bits 12:8 hold the de-glitch count D, which resets to 1; a value of 0 acts as 1. A level change that lasts fewer than D ticks is ignored. Longer runs keep their measured width.
- R10: Address 2 holds the period value P, which resets to 0. A sample tick occurs every P+1 clock cycles, and widths are counted in ticks.
- R11: The idle high level before the first accepted falling edge is never recorded. Capture begins only on that falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_in | input | 1 | Raw demodulated receiver output, active low |
| reg_addr | input | 6 | Register word address |
| reg_wr | input | 1 | Write strobe for the current address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current address (combinational) |
| irq_o | output | 1 | Level interrupt: pending flag AND interrupt enable |

## Verification
The assertions check four things on every cycle. The write index never passes the store size. A finished message stays finished until it is restarted. A restart always returns the engine to idle at entry 0. Each finish event sets the pending flag, and an acknowledge with no new finish event clears it. They also check that filter edges always flip the level and that ticks are spaced by the period. The actual byte values depend on input timing, so only the directed scenarios can show them. These cover saturation, the zero written on timeout, de-glitch rejection of short runs, tick scaling under a non-zero period, byte packing order, and the contents after a full store.

// File: rtl/ircap_pkg.sv
package ircap_pkg;
  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_RUN  = 2'd1,
    CAP_DONE = 2'd2
  } cap_state_e;

  // register word addresses
  localparam int unsigned ADR_CFG      = 0;
  localparam int unsigned ADR_FILT     = 1;
  localparam int unsigned ADR_PERIOD   = 2;
  localparam int unsigned ADR_RESTART  = 3;
  localparam int unsigned ADR_IRQ_EN   = 4;
  localparam int unsigned ADR_IRQ_STAT = 5;
  localparam int unsigned ADR_DATA     = 16;

  // field positions
  localparam int unsigned CFG_EN_BIT   = 0;
  localparam int unsigned CFG_MEAS_BIT = 13;
  localparam int unsigned CFG_COMP_LSB = 16;
  localparam int unsigned COMP_W       = 7;
  localparam int unsigned DG_LSB       = 8;
  localparam int unsigned DG_W         = 5;
endpackage

// File: rtl/ircap_tick.sv
module ircap_tick #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [PERIOD_W-1:0] period,
  output logic                tick
);
  logic [PERIOD_W-1:0] cnt;

  assign tick = run && (cnt >= period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (cnt >= period) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R10: with a non-zero period, ticks are never back to back
  p_tick_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && period != '0) |=> (!tick || period != $past(period)));
endmodule

// File: rtl/ircap_filter.sv
module ircap_filter #(
  parameter int DG_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            raw,
  input  logic            run,
  input  logic            tick,
  input  logic [DG_W-1:0] dg,
  output logic            lvl,
  output logic            edge_stb
);
  logic [1:0]    sync;
  logic [DG_W:0] run_cnt;
  logic [DG_W:0] need;

  assign need = (dg == '0) ? (DG_W+1)'(1) : {1'b0, dg};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11;
    end else begin
      sync <= {sync[0], raw};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl      <= 1'b1;
      run_cnt  <= '0;
      edge_stb <= 1'b0;
    end else begin
      edge_stb <= 1'b0;
      if (run && tick) begin
        if (sync[1] != lvl) begin
          if (run_cnt + 1'b1 >= need) begin
            lvl      <= sync[1];
            run_cnt  <= '0;
            edge_stb <= 1'b1;
          end else begin
            run_cnt <= run_cnt + 1'b1;
          end
        end else begin
          run_cnt <= '0;
        end
      end
    end
  end

  // R9: every accepted edge flips the filtered level
  p_edge_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    edge_stb |-> (lvl != $past(lvl)));
endmodule

// File: rtl/ircap_store.sv
module ircap_store
  import ircap_pkg::*;
#(
  parameter int NUM_WORDS = 17,
  parameter int CW        = 7,
  parameter int SEL_W     = $clog2(NUM_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             edge_stb,
  input  logic             lvl,
  input  logic             restart,
  input  logic [CW-1:0]    comp,
  input  logic [SEL_W-1:0] word_sel,
  output logic [31:0]      word_data,
  output logic             done_stb
);
  localparam int ENTRIES = NUM_WORDS * 4;
  localparam int IDX_W   = $clog2(ENTRIES + 1);
  localparam int CNT_W   = CW + 8;

  cap_state_e       state;
  logic [IDX_W-1:0] idx;
  logic             phase;   // 0 pulse, 1 space
  logic [CNT_W-1:0] cnt;
  logic [7:0]       mem [ENTRIES];
  logic [7:0]       sat;
  logic             timeout;

  assign sat     = (|cnt[CNT_W-1:8]) ? 8'hFF : cnt[7:0];
  assign timeout = phase && (comp != '0) && (cnt >= {comp, 8'h00});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= CAP_IDLE;
      idx      <= '0;
      phase    <= 1'b0;
      cnt      <= '0;
      done_stb <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) mem[i] <= 8'h00;
    end else begin
      done_stb <= 1'b0;
      if (restart) begin
        state <= CAP_IDLE;
        idx   <= '0;
        phase <= 1'b0;
        cnt   <= '0;
        for (int i = 0; i < ENTRIES; i++) mem[i] <= 8'h00;
      end else begin
        case (state)
          CAP_IDLE: begin
            if (run && edge_stb && !lvl) begin
              state <= CAP_RUN;
              phase <= 1'b0;
              idx   <= '0;
              cnt   <= CNT_W'(tick);
            end
          end
          CAP_RUN: begin
            if (run) begin
              if (edge_stb) begin
                mem[idx] <= sat;
                idx      <= idx + 1'b1;
                phase    <= ~phase;
                cnt      <= CNT_W'(tick);
                if (idx == IDX_W'(ENTRIES - 1)) begin
                  state    <= CAP_DONE;
                  done_stb <= 1'b1;
                end
              end else if (timeout) begin
                mem[idx] <= 8'h00;
                state    <= CAP_DONE;
                done_stb <= 1'b1;
              end else if (tick && !(&cnt)) begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    word_data = '0;
    for (int b = 0; b < 4; b++) begin
      if ((int'(word_sel) * 4 + b) < ENTRIES)
        word_data[8*b +: 8] = mem[int'(word_sel) * 4 + b];
    end
  end

  // R4: write index never passes the store size
  p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IDX_W'(ENTRIES));
  // R4: a finished message stays finished until restart
  p_done_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CAP_DONE && !restart) |=> state == CAP_DONE);
  // R6: restart returns to idle at entry 0
  p_restart_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (state == CAP_IDLE && idx == '0));
  // R11: idle is left only through an accepted falling edge
  p_start_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CAP_IDLE && !(run && edge_stb && !lvl)) |=> state == CAP_IDLE);
endmodule

// File: rtl/ircap_top.sv
module ircap_top
  import ircap_pkg::*;
#(
  parameter int NUM_WORDS = 17,
  parameter int PERIOD_W  = 16,
  parameter int ADDR_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ir_in,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_o
);
  localparam int SEL_W = $clog2(NUM_WORDS);

  logic                cfg_en, cfg_meas;
  logic [COMP_W-1:0]   cfg_comp;
  logic [DG_W-1:0]     cfg_dg;
  logic [PERIOD_W-1:0] cfg_period;
  logic                irq_en, irq_pend;
  logic                run, tick, lvl, edge_stb, done_stb;
  logic                restart, ack_wr;
  logic                in_data;
  logic [SEL_W-1:0]    word_sel;
  logic [31:0]         word_data;

  assign run     = cfg_en && cfg_meas;
  assign restart = reg_wr && (reg_addr == ADDR_W'(ADR_RESTART)) && reg_wdata[0];
  assign ack_wr  = reg_wr && (reg_addr == ADDR_W'(ADR_IRQ_STAT)) && reg_wdata[0];
  assign in_data = (reg_addr >= ADDR_W'(ADR_DATA)) &&
                   (reg_addr < ADDR_W'(ADR_DATA + NUM_WORDS));
  assign word_sel = SEL_W'(reg_addr - ADDR_W'(ADR_DATA));
  assign irq_o   = irq_pend && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en     <= 1'b0;
      cfg_meas   <= 1'b0;
      cfg_comp   <= '0;
      cfg_dg     <= DG_W'(1);
      cfg_period <= '0;
      irq_en     <= 1'b0;
    end else if (reg_wr) begin
      case (int'(reg_addr))
        ADR_CFG: begin
          cfg_en   <= reg_wdata[CFG_EN_BIT];
          cfg_meas <= reg_wdata[CFG_MEAS_BIT];
          cfg_comp <= reg_wdata[CFG_COMP_LSB +: COMP_W];
        end
        ADR_FILT:   cfg_dg     <= reg_wdata[DG_LSB +: DG_W];
        ADR_PERIOD: cfg_period <= reg_wdata[PERIOD_W-1:0];
        ADR_IRQ_EN: irq_en     <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irq_pend <= 1'b0;
    else if (done_stb) irq_pend <= 1'b1;
    else if (ack_wr)   irq_pend <= 1'b0;
  end

  always_comb begin
    reg_rdata = '0;
    if (in_data) begin
      reg_rdata = word_data;
    end else begin
      case (int'(reg_addr))
        ADR_CFG: begin
          reg_rdata[CFG_EN_BIT]              = cfg_en;
          reg_rdata[CFG_MEAS_BIT]            = cfg_meas;
          reg_rdata[CFG_COMP_LSB +: COMP_W]  = cfg_comp;
        end
        ADR_FILT:     reg_rdata[DG_LSB +: DG_W]    = cfg_dg;
        ADR_PERIOD:   reg_rdata[PERIOD_W-1:0]      = cfg_period;
        ADR_IRQ_EN:   reg_rdata[0]                 = irq_en;
        ADR_IRQ_STAT: reg_rdata[0]                 = irq_pend;
        default: ;
      endcase
    end
  end

  ircap_tick #(.PERIOD_W(PERIOD_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .period(cfg_period), .tick(tick)
  );

  ircap_filter #(.DG_W(DG_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .raw(ir_in), .run(run), .tick(tick),
    .dg(cfg_dg), .lvl(lvl), .edge_stb(edge_stb)
  );

  ircap_store #(.NUM_WORDS(NUM_WORDS), .CW(COMP_W), .SEL_W(SEL_W)) u_store (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .edge_stb(edge_stb),
    .lvl(lvl), .restart(restart), .comp(cfg_comp), .word_sel(word_sel),
    .word_data(word_data), .done_stb(done_stb)
  );

  // R3: every finish event leaves the pending flag set
  p_done_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_stb |=> irq_pend);
  // R7: acknowledge without a new finish clears pending
  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !done_stb) |=> !irq_pend);
endmodule

// File: tb/ircap_top_test.sv
module ircap_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ir_in = 1'b1;
  logic [5:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;
  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] v;

  always #10 clk = ~clk;

  ircap_top uut (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = 6'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 6'(a);
    #1 d = reg_rdata;
  endtask

  task automatic lo(input int n);
    @(negedge clk); ir_in = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic hi(input int n);
    @(negedge clk); ir_in = 1'b1;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic setup(input int period, input int dg, input int comp, input bit meas);
    wr(2, 32'(period));
    wr(1, 32'(dg) << 8);
    wr(0, (32'(comp) << 16) | (32'(meas) << 13) | 32'h1);
    wr(4, 32'h1);
    wr(3, 32'h1);
    wr(5, 32'h1);
    hi(8);
  endtask

  task automatic t_reset;
    rd(0, v);  check("R8 cfg reset", v, 32'h0);
    rd(1, v);  check("R9 dg reset", v, 32'h100);
    rd(2, v);  check("R10 period reset", v, 32'h0);
    rd(16, v); check("R5 word0 reset", v, 32'h0);
    check("R7 irq reset", 32'(irq_o), 32'h0);
  endtask

  task automatic t_basic;
    setup(0, 1, 1, 1);
    rd(0, v); check("R8 cfg readback", v, 32'h0001_2001);
    lo(5); hi(7); lo(9); hi(11); lo(13); hi(400);
    rd(16, v); check("R1 R5 R11 word0", v, 32'h0B09_0705);
    rd(17, v); check("R3 word1 timeout zero", v, 32'h0000_000D);
    rd(18, v); check("R3 word2 zero", v, 32'h0);
    check("R3 irq on timeout", 32'(irq_o), 32'h1);
    wr(5, 32'h1);
    rd(5, v); check("R7 ack clears status", v, 32'h0);
    check("R7 irq low after ack", 32'(irq_o), 32'h0);
  endtask

  task automatic t_irq_gate;
    setup(0, 1, 1, 1);
    wr(4, 32'h0);
    lo(4); hi(400);
    check("R7 irq masked", 32'(irq_o), 32'h0);
    rd(5, v); check("R7 status pending", v, 32'h1);
    wr(4, 32'h1);
    @(negedge clk);
    check("R7 irq after enable", 32'(irq_o), 32'h1);
  endtask

  task automatic t_sat;
    setup(0, 1, 1, 1);
    lo(300); hi(6); lo(4); hi(400);
    rd(16, v); check("R2 saturation", v, 32'h0004_06FF);
  endtask

  task automatic t_deglitch;
    setup(0, 4, 1, 1);
    lo(2); hi(20);
    rd(16, v); check("R9 glitch ignored", v, 32'h0);
    rd(5, v);  check("R9 no message from glitch", v, 32'h0);
    lo(8); hi(2); lo(8); hi(6); lo(5); hi(400);
    rd(16, v); check("R9 glitch inside pulse", v, 32'h0005_0612);
  endtask

  task automatic t_prescale;
    setup(3, 1, 1, 1);
    lo(40); hi(20); lo(12); hi(1300);
    rd(16, v); check("R10 tick scaling", v, 32'h0003_050A);
    check("R10 R3 irq", 32'(irq_o), 32'h1);
  endtask

  task automatic t_full;
    setup(0, 1, 0, 1);
    for (int i = 0; i < 35; i++) begin lo(3); hi(3); end
    lo(7); hi(9); lo(2); hi(5);
    for (int w = 0; w < 17; w++) begin
      rd(16 + w, v); check("R4 full store word", v, 32'h0303_0303);
    end
    check("R4 irq on full", 32'(irq_o), 32'h1);
  endtask

  task automatic t_restart;
    wr(3, 32'h1);
    rd(16, v); check("R6 word0 cleared", v, 32'h0);
    rd(32, v); check("R6 word16 cleared", v, 32'h0);
    setup(0, 1, 1, 1);
    lo(4); hi(400);
    rd(16, v); check("R6 new message at entry 0", v, 32'h0000_0004);
  endtask

  task automatic t_disable;
    setup(0, 1, 1, 0);
    lo(5); hi(400);
    rd(16, v); check("R8 no capture without measure enable", v, 32'h0);
    check("R8 no irq when disabled", 32'(irq_o), 32'h0);
  endtask

  task automatic finish_run;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_basic;
    t_irq_gate;
    t_sat;
    t_deglitch;
    t_prescale;
    t_full;
    t_restart;
    t_disable;
    finish_run;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run;
  end
endmodule